// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block produces the raster scan for a cathode-ray display running on the pixel clock. It keeps a pixel counter and a line counter. From these and nine programmable timing values it drives a display-enable window, a horizontal sync pulse and a vertical sync pulse.

Software loads each 11-bit timing value as two byte writes on a byte-wide write port. A control byte starts and stops the counters. The same byte chooses which of two horizontal sync end points closes the horizontal pulse.

All horizontal values work in groups of four pixels. While the counters run, newly written timing values are held in shadow storage. They reach the comparators only when the frame wraps. While the counters are stopped, a write reaches the comparators on the next cycle.

Top module: `crt_raster_gen`

## Requirements
- R1: After reset the pixel count, line count, display enable, hsync and vsync are all 0. The control byte and every timing value are 0, so the counters stay stopped.
- R2: The control byte is at address 0x12. The timing values sit in pairs from 0x13 upward, low byte first and then high byte. The order is: horizontal total, display end, hsync start, hsync end A, hsync end B, vertical total, last visible line, vsync start, vsync end. Only bits 2:0 of a high-byte write are kept. A write to any other address changes nothing.
- R3: While control bit 0 is 0, both counters hold their value. A timing write reaches the comparators one cycle after the write cycle.
- R4: While control bit 0 is 1, the pixel count rises by one each clock. It returns to 0 after a pixel whose low two bits are 3 and whose upper bits equal the upper bits of horizontal total. A line is therefore (total with low bits cleared) + 4 pixels long. If that pixel is never met, the count wraps at 2047.
- R5: The line count advances when the pixel count wraps. It returns to 0 when it wraps from a line equal to vertical total.
- R6: Every horizontal comparison uses only bits 10:2 of the pixel count and of the horizontal value, so the low two bits of a horizontal value have no effect.
- R7: Display enable is 1 exactly when the pixel group is below the display-end group and the line count is at or below the last visible line.
- R8: Hsync is 1 when the pixel group is at or above the hsync-start group and below the end group. Control bit 1 chooses the end group: end B when the bit is 1, end A when it is 0.
- R9: Vsync is 1 when the line count is at or above vsync start and below vsync end.
- R10: While the counters run, a timing write takes effect only at the edge where the pixel count and the line count both wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write byte |
| h_count | output | 11 | Pixel position within the line |
| v_count | output | 11 | Line position within the frame |
| disp_en | output | 1 | Active display window |
| hsync | output | 1 | Horizontal sync pulse, active high |
| vsync | output | 1 | Vertical sync pulse, active high |

## Verification
The bench builds the block with its default parameters: 11-bit counters, four-pixel groups and 8-bit bytes. Every high-byte write therefore exercises the split of a value across two bytes. The bench programs a 40-pixel, 10-line raster, so a whole frame takes 400 clocks. Several frame wraps, mid-frame rewrites, stopped-counter writes and switches of the sync end select all fit in a short run.

Horizontal values are written with nonzero low bits to show that the four-pixel grouping hides them. Writes to addresses just outside the register range are included, and the line total is shortened during a frame.

// File: rtl/crt_pkg.sv
package crt_pkg;
    // number of 11-bit timing values and their slot order (address order)
    localparam int NUM_T    = 9;
    localparam int T_HTOT   = 0;
    localparam int T_HDE    = 1;
    localparam int T_HSS    = 2;
    localparam int T_HSEA   = 3;
    localparam int T_HSEB   = 4;
    localparam int T_VTOT   = 5;
    localparam int T_VDE    = 6;
    localparam int T_VSS    = 7;
    localparam int T_VSE    = 8;

    localparam logic [7:0] CTRL_ADDR  = 8'h12;
    localparam logic [7:0] TIME_BASE  = 8'h13;

    localparam int RUN_BIT  = 0;
    localparam int ALT_BIT  = 1;
endpackage

// File: rtl/crt_timing_regs.sv
module crt_timing_regs
    import crt_pkg::*;
#(
    parameter int CW = 11,
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [DW-1:0]              wr_data,
    input  logic                       frame_wrap,
    output logic [DW-1:0]              ctrl_q,
    output logic [NUM_T-1:0][CW-1:0]   act_q
);
    localparam int HI_W = CW - DW;

    typedef struct packed {
        logic [DW-1:0]            ctrl;
        logic [NUM_T-1:0][CW-1:0] shadow;
        logic [NUM_T-1:0][CW-1:0] active;
    } regs_t;

    regs_t         r_d, r_q;
    logic [AW-1:0] offs_d;
    logic          in_range_d;

    always_comb begin
        r_d        = r_q;
        offs_d     = wr_addr - AW'(TIME_BASE);
        in_range_d = (wr_addr >= AW'(TIME_BASE));
        // shadow -> active: continuously when stopped, at frame wrap when running
        if (!r_q.ctrl[RUN_BIT] || frame_wrap) begin
            r_d.active = r_q.shadow;
        end
        if (wr_en) begin
            if (wr_addr == AW'(CTRL_ADDR)) begin
                r_d.ctrl = wr_data;
            end
            for (int k = 0; k < NUM_T; k++) begin
                if (in_range_d && offs_d == AW'(2 * k)) begin
                    r_d.shadow[k][DW-1:0] = wr_data;
                end
                if (in_range_d && offs_d == AW'(2 * k + 1)) begin
                    r_d.shadow[k][CW-1:DW] = wr_data[HI_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_q = r_q.ctrl;
    assign act_q  = r_q.active;
endmodule

// File: rtl/crt_counters.sv
module crt_counters #(
    parameter int CW = 11,
    parameter int GB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] vtot,
    output logic [CW-1:0] h_q,
    output logic [CW-1:0] v_q,
    output logic          frame_wrap
);
    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } cnt_t;

    cnt_t c_d, c_q;
    logic line_end_d;

    always_comb begin
        c_d        = c_q;
        line_end_d = (c_q.h[GB-1:0] == '1) && (c_q.h[CW-1:GB] == htot[CW-1:GB]);
        frame_wrap = run && line_end_d && (c_q.v == vtot);
        if (run) begin
            if (line_end_d) begin
                c_d.h = '0;
                c_d.v = (c_q.v == vtot) ? '0 : c_q.v + CW'(1);
            end else begin
                c_d.h = c_q.h + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign h_q = c_q.h;
    assign v_q = c_q.v;
endmodule

// File: rtl/crt_sync_decode.sv
module crt_sync_decode #(
    parameter int CW = 11,
    parameter int GB = 2
) (
    input  logic [CW-1:0] h,
    input  logic [CW-1:0] v,
    input  logic [CW-1:0] hde,
    input  logic [CW-1:0] hss,
    input  logic [CW-1:0] hse_a,
    input  logic [CW-1:0] hse_b,
    input  logic [CW-1:0] vde,
    input  logic [CW-1:0] vss,
    input  logic [CW-1:0] vse,
    input  logic          alt,
    output logic          disp,
    output logic          hs,
    output logic          vs
);
    localparam int GW = CW - GB;

    logic [GW-1:0] grp_d;
    logic [CW-1:0] hend_d;

    always_comb begin
        grp_d  = h[CW-1:GB];
        hend_d = alt ? hse_b : hse_a;
        disp   = (grp_d < hde[CW-1:GB]) && (v <= vde);
        hs     = (grp_d >= hss[CW-1:GB]) && (grp_d < hend_d[CW-1:GB]);
        vs     = (v >= vss) && (v < vse);
    end
endmodule

// File: rtl/crt_raster_gen.sv
module crt_raster_gen
    import crt_pkg::*;
#(
    parameter int CW = 11,
    parameter int GB = 2,
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] h_count,
    output logic [CW-1:0] v_count,
    output logic          disp_en,
    output logic          hsync,
    output logic          vsync
);
    logic [DW-1:0]            ctrl_q;
    logic [NUM_T-1:0][CW-1:0] act_q;
    logic                     frame_wrap;

    crt_timing_regs #(.CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_wrap (frame_wrap),
        .ctrl_q     (ctrl_q),
        .act_q      (act_q)
    );

    crt_counters #(.CW(CW), .GB(GB)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_q[RUN_BIT]),
        .htot       (act_q[T_HTOT]),
        .vtot       (act_q[T_VTOT]),
        .h_q        (h_count),
        .v_q        (v_count),
        .frame_wrap (frame_wrap)
    );

    crt_sync_decode #(.CW(CW), .GB(GB)) u_dec (
        .h     (h_count),
        .v     (v_count),
        .hde   (act_q[T_HDE]),
        .hss   (act_q[T_HSS]),
        .hse_a (act_q[T_HSEA]),
        .hse_b (act_q[T_HSEB]),
        .vde   (act_q[T_VDE]),
        .vss   (act_q[T_VSS]),
        .vse   (act_q[T_VSE]),
        .alt   (ctrl_q[ALT_BIT]),
        .disp  (disp_en),
        .hs    (hsync),
        .vs    (vsync)
    );
endmodule

// File: rtl/crt_raster_gen_chk.sv
module crt_raster_gen_chk #(
    parameter int CW  = 11,
    parameter int GB  = 2,
    parameter int NUM = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run,
    input logic                    alt,
    input logic [CW-1:0]           h,
    input logic [CW-1:0]           v,
    input logic                    disp,
    input logic                    hs,
    input logic [NUM-1:0][CW-1:0]  act
);
    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(h) && $stable(v)));

    assert_pixel_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h[GB-1:0] != '1) |=> (h == $past(h) + CW'(1)));

    assert_line_moves_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(v) |-> (h == '0));

    assert_disp_rises_at_line_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $rose(disp)) |-> (h == '0));

    assert_hsync_rises_on_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $stable(alt) && $rose(hs)) |-> (h[GB-1:0] == '0));

    assert_update_at_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$stable(act)) |-> (h == '0 && v == '0));
endmodule

bind crt_raster_gen crt_raster_gen_chk #(.CW(CW), .GB(GB), .NUM(crt_pkg::NUM_T)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl_q[0]),
    .alt   (ctrl_q[1]),
    .h     (h_count),
    .v     (v_count),
    .disp  (disp_en),
    .hs    (hsync),
    .act   (act_q)
);

// File: tb/crt_raster_gen_test.sv
module crt_raster_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic [10:0] h_count, v_count;
    logic        disp_en, hsync, vsync;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit monitor_on = 0;

    // reference model state
    int m_sh[9];
    int m_ac[9];
    int m_ctrl = 0;
    int m_h = 0;
    int m_v = 0;

    crt_raster_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .h_count(h_count), .v_count(v_count), .disp_en(disp_en), .hsync(hsync), .vsync(vsync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 9; k++) begin
                m_sh[k] = 0;
                m_ac[k] = 0;
            end
            m_ctrl = 0;
            m_h = 0;
            m_v = 0;
        end else begin
            bit run_now;
            bit at_line_end;
            bit at_frame_end;
            run_now      = (m_ctrl % 2) == 1;
            at_line_end  = (m_h % 4 == 3) && (m_h / 4 == m_ac[0] / 4);
            at_frame_end = run_now && at_line_end && (m_v == m_ac[5]);
            if (run_now) begin
                if (at_line_end) begin
                    m_h = 0;
                    m_v = (m_v == m_ac[5]) ? 0 : (m_v + 1) % 2048;
                end else begin
                    m_h = (m_h + 1) % 2048;
                end
            end
            if (!run_now || at_frame_end) begin
                for (int k = 0; k < 9; k++) m_ac[k] = m_sh[k];
            end
            if (wr_en) begin
                int a;
                a = int'(wr_addr);
                if (a == 'h12) begin
                    m_ctrl = int'(wr_data);
                end else if (a >= 'h13 && a < 'h13 + 18) begin
                    int k;
                    k = (a - 'h13) / 2;
                    if ((a - 'h13) % 2 == 0) m_sh[k] = (m_sh[k] / 256) * 256 + int'(wr_data);
                    else                     m_sh[k] = (m_sh[k] % 256) + (int'(wr_data) % 8) * 256;
                end
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (monitor_on && !finished) begin
            int hend;
            int exp_disp, exp_hs, exp_vs;
            hend     = ((m_ctrl / 2) % 2 == 1) ? m_ac[4] : m_ac[3];
            exp_disp = ((m_h / 4 < m_ac[1] / 4) && (m_v <= m_ac[6])) ? 1 : 0;
            exp_hs   = ((m_h / 4 >= m_ac[2] / 4) && (m_h / 4 < hend / 4)) ? 1 : 0;
            exp_vs   = ((m_v >= m_ac[7]) && (m_v < m_ac[8])) ? 1 : 0;
            chk("R4 h_count", int'(h_count), m_h);
            chk("R5 v_count", int'(v_count), m_v);
            chk("R7 disp_en", int'(disp_en), exp_disp);
            chk("R8 hsync", int'(hsync), exp_hs);
            chk("R9 vsync", int'(vsync), exp_vs);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [7:0] a, input int val);
        wr(a, 8'(val % 256));
        wr(a + 8'd1, 8'(val / 256));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 h_count", int'(h_count), 0);
        chk("R1 v_count", int'(v_count), 0);
        chk("R1 disp_en", int'(disp_en), 0);
        chk("R1 hsync", int'(hsync), 0);
        chk("R1 vsync", int'(vsync), 0);
        monitor_on = 1;

        // R2: program timings while stopped; stray addresses ignored
        wr(8'h11, 8'hFF);
        wr(8'h25, 8'hFF);
        wr16(8'h13, 36);
        wr16(8'h15, 25);        // R6: low bits set, acts as 24
        wr16(8'h17, 28);
        wr16(8'h19, 32);
        wr16(8'h1B, 36);
        wr16(8'h1D, 9);
        wr16(8'h1F, 5);
        wr16(8'h21, 6);
        wr16(8'h23, 8);
        @(negedge clk); #1;
        chk("R2 disp_en after load", int'(disp_en), 1);
        // R3: stopped counters hold
        idle(5); #1;
        chk("R3 h held", int'(h_count), 0);

        // run plain frames
        wr(8'h12, 8'h01);
        idle(600);

        // R10: shorten the frame mid-frame; current frame still reaches line 9
        while (v_count != 11'd2) @(negedge clk);
        wr(8'h1D, 8'd4);
        begin
            bit seen9;
            seen9 = 0;
            for (int i = 0; i < 500; i++) begin
                @(negedge clk); #1;
                if (v_count == 11'd9) seen9 = 1;
            end
            chk("R10 deferred total", int'(seen9), 1);
        end
        idle(450);

        // R8: alternate sync end
        wr(8'h12, 8'h03);
        idle(450);
        // R6: end A with low bits set, same group as 32
        wr16(8'h19, 33);
        idle(450);

        // R3: stop mid-line, immediate update while stopped
        while (h_count != 11'd10) @(negedge clk);
        wr(8'h12, 8'h02);
        begin
            int h0;
            #1 h0 = int'(h_count);
            idle(5); #1;
            chk("R3 h stable", int'(h_count), h0);
        end
        wr16(8'h1B, 32);
        idle(3);
        wr(8'h12, 8'h03);
        idle(500);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule